// File: doc/BRIEF.md
# Peripheral Window Bus Acknowledge Decoder

This block watches bus cycles on a 24-bit address bus and decides whether an access aimed at a relocatable 4 KB on-chip peripheral window should be acknowledged. The window sits wherever a programmable base field places it. Inside the window, the block returns an acknowledge only for offsets that really exist:

- Implemented control registers are always acknowledged.
- Gaps between registers are never acknowledged.
- The two on-chip RAM regions at the top of the window are acknowledged only while their owning controller is held in reset.

Any access inside the window that is refused raises a one-clock illegal-access flag. An external bus-error timer can then end the cycle.

The bus is 16 bits wide, so the block sees the word address (bits 23 down to 1). Byte lanes within a word are not distinguished. The decision is taken once, on the first clock that sees the address strobe, and is held until the strobe is released. A plain window decoder would acknowledge every offset. This decoder stays silent on holes and on locked RAM, so that software bugs surface as bus errors.

Top module: `pwin_ack_top`

## Requirements
- R1: An access hits the window when word address bits [23:12] equal `baseField`. On the first clock edge that samples `accStrobe` high, `windowHit` goes high. It stays high until the first edge that samples `accStrobe` low.
- R2: Implemented register offsets compare on bits [11:1], so both bytes of a word are acknowledged. The default list is 0x000, 0x002, 0x004, 0x006, 0x008, 0x00A, 0x010 and 0x012. An access to one of these offsets raises `dtack` one clock after `accStrobe` is first sampled high.
- R3: An offset below 0xA00 that is not in the list is a hole, for example 0x00C or 0x020. An access to a hole never raises `dtack` and raises `illegalAccess` instead.
- R4: Offsets 0xA00 to 0xBFF are acknowledged only when `ctrlHeld` is 1. When `ctrlHeld` is 0 they are illegal.
- R5: Offsets 0xC00 to 0xFFF are acknowledged only when `ctrlHeld` is 1. When `ctrlHeld` is 0 they are illegal.
- R6: `illegalAccess` is high for exactly one clock per refused access. `dtack` and `illegalAccess` are never high together.
- R7: `dtack` stays high while `accStrobe` is held. It falls one clock after `accStrobe` is first sampled low.
- R8: An access outside the window raises none of `windowHit`, `dtack` or `illegalAccess`.
- R9: After reset, all three outputs are low.
- R10: The decision is captured at the start of an access. A change of `ctrlHeld` or of the address while `accStrobe` stays high has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordAddr | input | 23 | Word address, bus bits 23..1 |
| accStrobe | input | 1 | Address strobe, active high |
| baseField | input | 12 | Window base, bus bits 23..12 |
| ctrlHeld | input | 1 | 1 = RAM owner held in reset (RAM accessible) |
| windowHit | output | 1 | Current access is inside the window |
| dtack | output | 1 | Data transfer acknowledge |
| illegalAccess | output | 1 | One-clock pulse for a refused in-window access |

## Verification
The hardest situation to reach is a change in the conditions during an access that is already under way. The RAM-enable bit can drop, or the address can wander into a hole, while the strobe stays high. The stimulus starts an acknowledged RAM access with `ctrlHeld` high and lets the decision be captured. It then clears `ctrlHeld` and moves the address to a hole for several more clocks. Throughout, it checks that `dtack` stays high and that no illegal pulse appears. The window is also relocated to the top of the address space so that the base compare is exercised with all-ones bits.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef struct packed {
    logic start;   // first clock of an access: capture the decision
    logic finish;  // strobe released: drop the outputs
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } accState_t;
endpackage

// File: rtl/pwin_control.sv
module pwin_control
  import pwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accStrobe,
  output ctlStrobes_t strobes
);
  accState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (accStrobe)  state <= ST_BUSY;
        ST_BUSY: if (!accStrobe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.start  = (state == ST_IDLE) && accStrobe;
    strobes.finish = (state == ST_BUSY) && !accStrobe;
  end

  // R10: only one capture per strobe assertion
  p_single_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> !strobes.start);
endmodule

// File: rtl/pwin_datapath.sv
module pwin_datapath
  import pwin_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 12,
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS*WIN_BITS-1:0] REG_OFFSETS = {
    12'h012, 12'h010, 12'h00A, 12'h008, 12'h006, 12'h004, 12'h002, 12'h000},
  parameter logic [WIN_BITS-1:0] ARR_START = 12'hA00,
  parameter logic [WIN_BITS-1:0] BD_START  = 12'hC00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-2:0]      wordAddr,
  input  logic [ADDR_W-WIN_BITS-1:0] baseField,
  input  logic                   ctrlHeld,
  input  ctlStrobes_t            strobes,
  output logic                   hitQ,
  output logic                   dtackQ,
  output logic                   illegalQ
);
  localparam int OFF_W = WIN_BITS - 1;   // word offset width

  logic [OFF_W-1:0]    offWord;
  logic [NUM_REGS-1:0] matchVec;
  logic                inWindow;
  logic                inRegs;
  logic                inRam;
  logic                regImpl;
  logic                ackOk;

  assign offWord  = wordAddr[OFF_W-1:0];
  assign inWindow = (wordAddr[ADDR_W-2:OFF_W] == baseField);
  assign inRegs   = (offWord < ARR_START[WIN_BITS-1:1]);
  assign inRam    = !inRegs;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_regMatch
    assign matchVec[i] = (offWord == REG_OFFSETS[i*WIN_BITS+1 +: OFF_W]);
  end

  assign regImpl = |matchVec;
  // both RAM regions (from ARR_START and from BD_START) share the held gate
  assign ackOk   = inRegs ? regImpl : ctrlHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ     <= 1'b0;
      dtackQ   <= 1'b0;
      illegalQ <= 1'b0;
    end else if (strobes.start) begin
      hitQ     <= inWindow;
      dtackQ   <= inWindow && ackOk;
      illegalQ <= inWindow && !ackOk;
    end else begin
      illegalQ <= 1'b0;
      if (strobes.finish) begin
        hitQ   <= 1'b0;
        dtackQ <= 1'b0;
      end
    end
  end

  // R6: refusal is a single-clock pulse
  p_illegal_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |=> !illegalQ);

  // R4: locked RAM is refused at capture
  p_ram_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.start && inWindow && inRam && !ctrlHeld) |=> (!dtackQ && illegalQ));

  // R3: a hole below the RAM regions is never acknowledged
  p_hole_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.start && inWindow && inRegs && !regImpl) |=> !dtackQ);

  // R8: outside the window nothing is raised
  p_outside_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.start && !inWindow) |=> (!hitQ && !dtackQ && !illegalQ));

  // keep BD_START visible as the upper RAM region boundary
  initial assert (BD_START > ARR_START);
endmodule

// File: rtl/pwin_ack_top.sv
module pwin_ack_top
  import pwin_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 12,
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS*WIN_BITS-1:0] REG_OFFSETS = {
    12'h012, 12'h010, 12'h00A, 12'h008, 12'h006, 12'h004, 12'h002, 12'h000}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-2:0]          wordAddr,
  input  logic                       accStrobe,
  input  logic [ADDR_W-WIN_BITS-1:0] baseField,
  input  logic                       ctrlHeld,
  output logic                       windowHit,
  output logic                       dtack,
  output logic                       illegalAccess
);
  ctlStrobes_t strobes;

  pwin_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .accStrobe (accStrobe),
    .strobes   (strobes)
  );

  pwin_datapath #(
    .ADDR_W      (ADDR_W),
    .WIN_BITS    (WIN_BITS),
    .NUM_REGS    (NUM_REGS),
    .REG_OFFSETS (REG_OFFSETS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wordAddr  (wordAddr),
    .baseField (baseField),
    .ctrlHeld  (ctrlHeld),
    .strobes   (strobes),
    .hitQ      (windowHit),
    .dtackQ    (dtack),
    .illegalQ  (illegalAccess)
  );

  // R7: acknowledge is withdrawn one clock after the strobe drops
  p_dtack_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dtack && !accStrobe) |=> !dtack);

  // R1: an acknowledge only exists inside the window
  p_ack_in_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    dtack |-> windowHit);

  // R6: never both answers at once
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(dtack && illegalAccess));

  // R10: acknowledge held while strobe held
  p_ack_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dtack && accStrobe) |=> dtack);
endmodule

// File: tb/pwin_ack_top_tb.sv
module pwin_ack_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [22:0] wordAddr;
  logic        accStrobe;
  logic [11:0] baseField;
  logic        ctrlHeld;
  logic        windowHit;
  logic        dtack;
  logic        illegalAccess;

  int checkCount = 0;
  int failCount  = 0;

  // implemented offsets as stated in R2
  localparam logic [11:0] REG_LIST [8] = '{12'h000, 12'h002, 12'h004, 12'h006,
                                           12'h008, 12'h00A, 12'h010, 12'h012};

  always #(CLK_PERIOD/2) clk = ~clk;

  pwin_ack_top dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .wordAddr      (wordAddr),
    .accStrobe     (accStrobe),
    .baseField     (baseField),
    .ctrlHeld      (ctrlHeld),
    .windowHit     (windowHit),
    .dtack         (dtack),
    .illegalAccess (illegalAccess)
  );

  task automatic check(input string tag, input string what,
                       input logic actual, input logic expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, actual, expected);
    end
  endtask

  function automatic logic refAck(input logic [11:0] off, input logic held);
    logic found = 1'b0;
    if (off >= 12'hA00) return held;   // R4 / R5 RAM regions
    for (int i = 0; i < 8; i++)
      if (REG_LIST[i][11:1] == off[11:1]) found = 1'b1;
    return found;
  endfunction

  // one full access; expected values from the requirement model
  task automatic doAccess(input string tag, input logic [23:0] byteAddr,
                          input logic held);
    logic expHit;
    logic expAck;
    expHit = (byteAddr[23:12] == baseField);
    expAck = expHit && refAck(byteAddr[11:0], held);
    @(negedge clk);
    wordAddr  = byteAddr[23:1];
    ctrlHeld  = held;
    accStrobe = 1'b1;
    @(negedge clk);
    check(tag, "hit", windowHit, expHit);
    check(tag, "dtack", dtack, expAck);
    check(tag, "illegal", illegalAccess, expHit && !expAck);
    @(negedge clk);
    check("R6", "illegal second clock", illegalAccess, 1'b0);
    check("R7", "dtack held", dtack, expAck);
    accStrobe = 1'b0;
    @(negedge clk);
    check("R7", "dtack released", dtack, 1'b0);
    check("R1", "hit released", windowHit, 1'b0);
  endtask

  task automatic testReset();
    check("R9", "hit after reset", windowHit, 1'b0);
    check("R9", "dtack after reset", dtack, 1'b0);
    check("R9", "illegal after reset", illegalAccess, 1'b0);
  endtask

  task automatic testRegisters();
    doAccess("R2", 24'h123000, 1'b0);
    doAccess("R2", 24'h123005, 1'b0);   // odd byte of 0x004
    doAccess("R2", 24'h123013, 1'b0);   // last listed register
  endtask

  task automatic testHoles();
    doAccess("R3", 24'h123020, 1'b1);
    doAccess("R3", 24'h12300C, 1'b0);
    doAccess("R3", 24'h1239FE, 1'b1);
  endtask

  task automatic testRam();
    doAccess("R4", 24'h123A00, 1'b0);
    doAccess("R4", 24'h123BFE, 1'b1);
    doAccess("R5", 24'h123FFE, 1'b0);
    doAccess("R5", 24'h123C00, 1'b1);
  endtask

  task automatic testOutside();
    doAccess("R8", 24'h124000, 1'b1);
    doAccess("R8", 24'h122FFE, 1'b1);
  endtask

  task automatic testRelocate();
    baseField = 12'hFFF;
    doAccess("R1", 24'hFFF002, 1'b0);
    doAccess("R8", 24'h123002, 1'b0);
    baseField = 12'h123;
  endtask

  task automatic testMidChange();
    @(negedge clk);
    wordAddr  = 24'h123A10 >> 1;
    ctrlHeld  = 1'b1;
    accStrobe = 1'b1;
    @(negedge clk);
    check("R10", "dtack captured", dtack, 1'b1);
    ctrlHeld = 1'b0;
    wordAddr = 24'h123020 >> 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10", "dtack unaffected", dtack, 1'b1);
      check("R10", "no illegal", illegalAccess, 1'b0);
    end
    accStrobe = 1'b0;
    @(negedge clk);
    check("R7", "dtack released after long", dtack, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    wordAddr  = '0;
    accStrobe = 1'b0;
    baseField = 12'h123;
    ctrlHeld  = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testRegisters();
    testHoles();
    testRam();
    testOutside();
    testRelocate();
    testMidChange();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule